// File: doc/BRIEF.md
# Parallel Protection-Code Generator and Checker

This block guards short control transfers (command, message and status) on a 16-bit link with a six-bit cyclic code of minimum distance four. The generator side takes a 15-bit data word and returns the six check bits in the same cycle. The check bits sit in the low six bits of a protection byte, and its top two bits are zero. The protection byte is always produced, whether or not checking is turned on.

The receive side watches a 16-bit bus on which one transfer carries both bytes: the information byte on bits 7:0 and the protection byte on bits 15:8. On each valid transfer the block regenerates the check bits from the received information byte, zero-extended to 15 bits, and compares them with bus bits 13:8. It raises a one-cycle error flag on a mismatch, but only when checking is enabled and the phase is one that carries protection. A small control register holds the checking-enable state. An explicit request sets it. Reset, a hard reset, a target-port reset message and a change of transceiver mode clear it, and these clearing events win over a request in the same cycle.

Top module: `prot_code_unit`

## Requirements
- R1: `tx_check_o[5:0]` equals the six check bits of `tx_data_i` in the same cycle. Bit 0 is the XOR of data bits {13,11,10,7,6,5,3,2,1,0}. Bit 1 is the XOR of {14,12,11,8,7,6,4,3,2,1}. Bit 2 is the XOR of {12,11,10,9,8,6,4,1,0}. Bit 3 is the XOR of {13,12,11,10,9,7,5,2,1}. Bit 4 is the XOR of {14,13,12,11,10,8,6,3,2}. Bit 5 is the XOR of {14,12,10,9,6,5,4,2,1,0}.
- R2: `tx_check_o[7:6]` is always 0.
- R3: On receive, the reference word is `{7'b0, rx_bus_i[7:0]}` and the received check bits are `rx_bus_i[13:8]`. Bits 15:14 of the bus never affect `err_o`.
- R4: `err_o` is registered. It reflects a transfer strobed by `rx_valid_i` at one rising edge, is visible after that edge, and is 0 in any cycle that follows a cycle with `rx_valid_i` low.
- R5: `err_o` is set only if checking was enabled when the transfer was strobed and the regenerated and received check bits differ.
- R6: Phase encoding on `phase_i` is 0 information-unit, 1 command, 2 message and 3 status. An information-unit transfer never sets `err_o`, whatever the enable state.
- R7: Checking is disabled after `rst_ni`, and in the cycle after a clock edge that sees `hard_reset_i`, `port_reset_msg_i`, or a value of `xcvr_mode_i` different from the one seen at the previous edge (0 after reset).
- R8: `en_req_i` enables checking at a clock edge only when none of the R7 events occurs at that edge.
- R9: With checking enabled on a protected phase, every error of one, two or three bits in bus bits 13:0, and every odd-weight error there, sets `err_o`.
- R10: The protection byte on `tx_check_o` is produced correctly while checking is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| tx_data_i | input | 15 | Data word to protect |
| tx_check_o | output | 8 | Protection byte: check bits in 5:0, zeros in 7:6 |
| rx_valid_i | input | 1 | Received transfer strobe |
| rx_bus_i | input | 16 | Received bus: information byte 7:0, protection byte 15:8 |
| phase_i | input | 2 | Transfer phase (0 IU, 1 command, 2 message, 3 status) |
| en_req_i | input | 1 | Request to enable checking |
| hard_reset_i | input | 1 | Hard reset event |
| port_reset_msg_i | input | 1 | Target-port reset message event |
| xcvr_mode_i | input | 2 | Current transceiver mode; any change is a disabling event |
| err_o | output | 1 | Registered protection error flag |

## Verification
A stuck or stale enable register shows at the ports on the very next strobed bad word. The flag either appears after a disabling event or stays absent after a clean request, one edge after the strobe. A wrong XOR term shows in the same cycle on the generated byte for any data word that covers that bit. On the receive path it also shows as a flag on a clean codeword, or as no flag on a corrupted one, one edge after the strobe. A mode register that does not track the input shows as checking that survives a mode change, or that is killed by an unchanged mode.

// File: rtl/prot_code_pkg.sv
package prot_code_pkg;
  localparam int DATA_W = 15;
  localparam int CHK_W  = 6;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 2 * BYTE_W;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    PH_IU  = 2'd0,
    PH_CMD = 2'd1,
    PH_MSG = 2'd2,
    PH_STS = 2'd3
  } phase_e;

  // one row per check bit, bit i set when data bit i feeds it
  localparam logic [CHK_W-1:0][DATA_W-1:0] CHK_MASK = {
    15'h5677, 15'h7D4C, 15'h3EA6, 15'h1F53, 15'h59DE, 15'h2CEF
  };

  function automatic logic is_protected(input logic [1:0] ph);
    return ph != PH_IU;
  endfunction
endpackage

// File: rtl/prot_code_enc.sv
module prot_code_enc
  import prot_code_pkg::*;
#(
  parameter int IN_W  = DATA_W,
  parameter int OUT_W = CHK_W
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [OUT_W-1:0] chk_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    assign chk_o[k] = ^(data_i & CHK_MASK[k]);
  end
endmodule

// File: rtl/prot_chk_en_ctrl.sv
module prot_chk_en_ctrl
  import prot_code_pkg::*;
#(
  parameter int MW = MODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_req_i,
  input  logic          hard_reset_i,
  input  logic          port_reset_msg_i,
  input  logic [MW-1:0] xcvr_mode_i,
  output logic          chk_en_o,
  output logic [MW-1:0] mode_q_o
);
  logic          chk_en_q;
  logic [MW-1:0] mode_q;
  logic          kill;

  assign kill = hard_reset_i | port_reset_msg_i | (xcvr_mode_i != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_en_q <= 1'b0;
      mode_q   <= '0;
    end else begin
      mode_q <= xcvr_mode_i;
      if (kill)          chk_en_q <= 1'b0;
      else if (en_req_i) chk_en_q <= 1'b1;
    end
  end

  assign chk_en_o = chk_en_q;
  assign mode_q_o = mode_q;
endmodule

// File: rtl/prot_rx_check.sv
module prot_rx_check
  import prot_code_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [1:0]       phase_i,
  input  logic             chk_en_i,
  output logic             err_o
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [CHK_W-1:0] regen;
  logic [CHK_W-1:0] rcvd;
  logic             mismatch;
  logic             err_q;
  logic [BUS_W-CHK_W-BYTE_W-1:0] unused_pad;

  prot_code_enc #(.IN_W(DATA_W), .OUT_W(CHK_W)) u_regen (
    .data_i({{PAD_W{1'b0}}, bus_i[BYTE_W-1:0]}),
    .chk_o (regen)
  );

  assign rcvd       = bus_i[BYTE_W +: CHK_W];
  assign unused_pad = bus_i[BUS_W-1:BYTE_W+CHK_W];
  assign mismatch   = regen != rcvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= valid_i & chk_en_i & is_protected(phase_i) & mismatch;
  end

  assign err_o = err_q;
endmodule

// File: rtl/prot_code_unit.sv
module prot_code_unit
  import prot_code_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [14:0] tx_data_i,
  output logic [7:0]  tx_check_o,
  input  logic        rx_valid_i,
  input  logic [15:0] rx_bus_i,
  input  logic [1:0]  phase_i,
  input  logic        en_req_i,
  input  logic        hard_reset_i,
  input  logic        port_reset_msg_i,
  input  logic [1:0]  xcvr_mode_i,
  output logic        err_o
);
  logic [CHK_W-1:0]  tx_chk;
  logic              chk_en_q;
  logic [MODE_W-1:0] mode_q;

  prot_code_enc #(.IN_W(DATA_W), .OUT_W(CHK_W)) u_tx_enc (
    .data_i(tx_data_i),
    .chk_o (tx_chk)
  );

  assign tx_check_o = {{(BYTE_W-CHK_W){1'b0}}, tx_chk};

  prot_chk_en_ctrl #(.MW(MODE_W)) u_en (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_req_i        (en_req_i),
    .hard_reset_i    (hard_reset_i),
    .port_reset_msg_i(port_reset_msg_i),
    .xcvr_mode_i     (xcvr_mode_i),
    .chk_en_o        (chk_en_q),
    .mode_q_o        (mode_q)
  );

  prot_rx_check u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rx_valid_i),
    .bus_i   (rx_bus_i),
    .phase_i (phase_i),
    .chk_en_i(chk_en_q),
    .err_o   (err_o)
  );
endmodule

// File: rtl/prot_code_unit_chk.sv
module prot_code_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  tx_check_o,
  input logic        rx_valid_i,
  input logic [1:0]  phase_i,
  input logic        en_req_i,
  input logic        hard_reset_i,
  input logic        port_reset_msg_i,
  input logic [1:0]  xcvr_mode_i,
  input logic        err_o,
  input logic        chk_en_q,
  input logic [1:0]  mode_q
);
  assert_pad_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_check_o[7:6] == 2'b00);

  assert_err_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !err_o);

  assert_err_needs_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_en_q |=> !err_o);

  assert_iu_never_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'd0) |=> !err_o);

  assert_hard_reset_kills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_reset_i |=> !chk_en_q);

  assert_port_msg_kills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_reset_msg_i |=> !chk_en_q);

  assert_mode_change_kills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcvr_mode_i != mode_q) |=> !chk_en_q);

  assert_mode_tracks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mode_q == $past(xcvr_mode_i));

  assert_req_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_req_i && !hard_reset_i && !port_reset_msg_i && xcvr_mode_i == mode_q) |=> chk_en_q);

  assert_en_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_req_i && !chk_en_q) |=> !chk_en_q);
endmodule

bind prot_code_unit prot_code_unit_chk u_prot_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .tx_check_o      (tx_check_o),
  .rx_valid_i      (rx_valid_i),
  .phase_i         (phase_i),
  .en_req_i        (en_req_i),
  .hard_reset_i    (hard_reset_i),
  .port_reset_msg_i(port_reset_msg_i),
  .xcvr_mode_i     (xcvr_mode_i),
  .err_o           (err_o),
  .chk_en_q        (chk_en_q),
  .mode_q          (mode_q)
);

// File: tb/tb_prot_code_unit.sv
module tb_prot_code_unit;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [1:0]  ph;
    logic [7:0]  info;
    logic [15:0] flip;
    logic        exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'hA5, 16'h0001, 1'b1},
    '{2'd1, 8'h3C, 16'h0100, 1'b1},
    '{2'd2, 8'h00, 16'h2000, 1'b1},
    '{2'd3, 8'hFF, 16'h0003, 1'b1},
    '{2'd1, 8'h5A, 16'h0700, 1'b1},
    '{2'd2, 8'h81, 16'h0181, 1'b1},
    '{2'd3, 8'h7E, 16'h1F00, 1'b1},
    '{2'd1, 8'hC3, 16'h3F01, 1'b1},
    '{2'd1, 8'h96, 16'h0000, 1'b0},
    '{2'd3, 8'h96, 16'hC000, 1'b0},
    '{2'd2, 8'h11, 16'h4000, 1'b0},
    '{2'd0, 8'h42, 16'h0101, 1'b0},
    '{2'd0, 8'h42, 16'h0000, 1'b0},
    '{2'd3, 8'h00, 16'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] tx_data = '0;
  logic [7:0]  tx_check;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_bus = '0;
  logic [1:0]  phase = '0;
  logic        en_req = 1'b0;
  logic        hard_rst = 1'b0;
  logic        port_msg = 1'b0;
  logic [1:0]  mode = '0;
  logic        err;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prot_code_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_check_o(tx_check),
    .rx_valid_i(rx_valid), .rx_bus_i(rx_bus), .phase_i(phase),
    .en_req_i(en_req), .hard_reset_i(hard_rst), .port_reset_msg_i(port_msg),
    .xcvr_mode_i(mode), .err_o(err)
  );

  function automatic logic [5:0] ref_chk(input logic [14:0] d);
    logic [5:0] r;
    r[0] = d[0]^d[1]^d[2]^d[3]^d[5]^d[6]^d[7]^d[10]^d[11]^d[13];
    r[1] = d[1]^d[2]^d[3]^d[4]^d[6]^d[7]^d[8]^d[11]^d[12]^d[14];
    r[2] = d[0]^d[1]^d[4]^d[6]^d[8]^d[9]^d[10]^d[11]^d[12];
    r[3] = d[1]^d[2]^d[5]^d[7]^d[9]^d[10]^d[11]^d[12]^d[13];
    r[4] = d[2]^d[3]^d[6]^d[8]^d[10]^d[11]^d[12]^d[13]^d[14];
    r[5] = d[0]^d[1]^d[2]^d[4]^d[5]^d[6]^d[9]^d[10]^d[12]^d[14];
    return r;
  endfunction

  task automatic check(input logic ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] ph, input logic [7:0] info, input logic [15:0] flip,
                      input logic exp, input string tag);
    rx_bus   = {2'b00, ref_chk({7'b0, info}), info} ^ flip;
    phase    = ph;
    rx_valid = 1'b1;
    #1;
    check(err == 1'b0, "R4 flag before edge", {15'b0, err}, 16'h0);
    @(negedge clk);
    rx_valid = 1'b0;
    check(err == exp, tag, {15'b0, err}, {15'b0, exp});
    @(negedge clk);
    check(err == 1'b0, "R4 flag clears", {15'b0, err}, 16'h0);
  endtask

  task automatic pulse_en();
    en_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0;
  endtask

  task automatic tx_sweep(input string tag);
    for (int i = 0; i < 15; i++) begin
      tx_data = 15'(1) << i;
      #1;
      check(tx_check == {2'b00, ref_chk(tx_data)}, tag, {8'b0, tx_check}, {10'b0, ref_chk(tx_data)});
    end
    for (int i = 0; i < 8; i++) begin
      tx_data = 15'(i * 15'h1357 + 15'h2AB1);
      #1;
      check(tx_check == {2'b00, ref_chk(tx_data)}, tag, {8'b0, tx_check}, {10'b0, ref_chk(tx_data)});
    end
    tx_data = 15'h7FFF;
    #1;
    check(tx_check == {2'b00, ref_chk(tx_data)}, tag, {8'b0, tx_check}, {10'b0, ref_chk(tx_data)});
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(err == 1'b0, "R7 reset flag", {15'b0, err}, 16'h0);
    check(tx_check == 8'h00, "R1 R2 zero word", {8'b0, tx_check}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    send(2'd1, 8'h5A, 16'h0100, 1'b0, "R7 disabled after power-up");
    tx_sweep("R10 R1 R2 tx while disabled");

    pulse_en();
    send(2'd1, 8'h5A, 16'h0100, 1'b1, "R5 enabled detects");

    for (int v = 0; v < NV; v++)
      send(VECS[v].ph, VECS[v].info, VECS[v].flip, VECS[v].exp, $sformatf("R3 R6 R9 vector %0d", v));

    tx_sweep("R1 R2 tx while enabled");

    hard_rst = 1'b1; @(negedge clk); hard_rst = 1'b0;
    send(2'd2, 8'h33, 16'h0200, 1'b0, "R7 hard reset disables");
    pulse_en();
    send(2'd2, 8'h33, 16'h0200, 1'b1, "R8 re-enable");

    port_msg = 1'b1; @(negedge clk); port_msg = 1'b0;
    send(2'd3, 8'hE7, 16'h0400, 1'b0, "R7 port reset message disables");
    pulse_en();

    mode = 2'd1; @(negedge clk);
    send(2'd3, 8'hE7, 16'h0400, 1'b0, "R7 mode change disables");
    pulse_en();
    send(2'd3, 8'hE7, 16'h0400, 1'b1, "R7 steady mode keeps enable");

    hard_rst = 1'b1; en_req = 1'b1; @(negedge clk); hard_rst = 1'b0; en_req = 1'b0;
    send(2'd1, 8'h0F, 16'h0010, 1'b0, "R8 hard reset beats request");
    port_msg = 1'b1; en_req = 1'b1; @(negedge clk); port_msg = 1'b0; en_req = 1'b0;
    send(2'd1, 8'h0F, 16'h0010, 1'b0, "R8 port message beats request");
    mode = 2'd2; en_req = 1'b1; @(negedge clk); en_req = 1'b0;
    send(2'd1, 8'h0F, 16'h0010, 1'b0, "R8 mode change beats request");
    pulse_en();
    send(2'd0, 8'h0F, 16'h0010, 1'b0, "R6 info-unit ignored when enabled");
    send(2'd1, 8'h0F, 16'h0010, 1'b1, "R8 request after events enables");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule